// File: doc/BRIEF.md
# Serial EEPROM Command Front-End

This block is the slave-side protocol engine of a small serial memory with 256 byte locations. A host talks to it over a four-wire serial link that uses clock-polarity and clock-phase settings 0/0 or 1/1. Input bits are captured on rising serial clock edges. Output bits change after falling edges. Every transaction starts with a one-byte command. An address byte and data bytes may follow, all sent most significant bit first. A hold input lets the host pause a transaction part-way and then resume it.

The serial clock, chip select, data input and hold input are each passed through a two-stage synchroniser into a faster system clock. Their edges are detected there, so the whole design runs in one clock domain. Inside the block sit a write-enable latch, a 2-bit protection field, a 16-byte page buffer and a timed internal write engine. The memory array is outside the block and is reached through a single address port that has a combinational read and a write strobe. An array write or status write is queued during the transaction and committed only when chip select rises cleanly on a byte boundary.

Top module: `spi_eeprom_fe`

## Requirements
- R1: After reset the output enable is low and a status read returns 0xF0. The status byte is laid out as follows: bits 7:4 always read 1, bits 3:2 hold the protection field, bit 1 holds the write-enable latch, and bit 0 is the write-in-progress flag.
- R2: Command 0x06 sets the write-enable latch and command 0x04 clears it. Both take effect as the eighth command bit is captured.
- R3: Command 0x05 shifts out the status byte MSB first, with each bit appearing after a falling clock edge. Once the eighth status bit has been clocked, the output enable stays low and further input is ignored until chip select rises.
- R4: Command 0x03 followed by an address byte streams array bytes starting at that address. The address increments after each byte and wraps from 0xFF to 0x00 without limit.
- R5: Command 0x02 (accepted only with the latch set) is followed by an address and 1 to 16 data bytes. The low 4 address bits wrap within the 16-byte page. Chip select rising on a byte boundary starts an internal cycle that writes only the received bytes. Write-in-progress is set for the whole cycle, and the latch clears when the cycle ends.
- R6: An array write is discarded, with the array and status unchanged, if the latch was clear or if any clock edge beyond a whole data byte arrives before chip select rises.
- R7: Command 0x01 with the latch set, followed by one byte, loads bits 3:2 of that byte into the protection field at the end of a timed cycle. During the cycle the old field still reads back. A ninth clock after the data byte discards the update.
- R8: A command byte outside {0x01, 0x02, 0x03, 0x04, 0x05, 0x06} makes the block ignore the rest of the transaction, including any later command bytes, and it produces no output.
- R9: While an internal cycle runs, every command other than 0x05 is rejected as in R8. An array read therefore yields no output.
- R10: Hold starts when the hold input falls while the clock is low, and ends when the hold input rises while the clock is low. While hold is active, the output enable is low and clock edges are ignored, so the transfer resumes exactly where it stopped.
- R11: The output enable is high only in the data phase of a 0x03 or 0x05 command. It drops within three system clocks of chip select rising.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| mosi | input | 1 | Serial data from host |
| hold_n | input | 1 | Pause request, active low |
| miso | output | 1 | Serial data to host |
| miso_oe | output | 1 | Drive enable for miso |
| mem_addr | output | AW | Array address (read and write) |
| mem_we | output | 1 | Array write strobe |
| mem_wdata | output | 8 | Array write data |
| mem_rdata | input | 8 | Array read data at mem_addr |

## Verification
A wrong bit counter or command state shows up in one of two ways. Either a status or array byte comes back misaligned within the very next transfer, or the output enable rises in a command or address phase. A page buffer that is lost or mis-indexed is not visible until the internal cycle ends. It then appears as array bytes in the wrong slots when the page is read back. A fault in the commit condition appears as a missing write-in-progress flag on the status read that immediately follows the deselect. A hold that fails to freeze the counter corrupts the byte in which the pause occurred.

// File: rtl/spi_eeprom_fe.sv
module spi_eeprom_fe #(
  parameter int AW         = 8,
  parameter int PAGE_BYTES = 16,
  parameter int WR_TICKS   = 200
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          sck,
  input  logic          mosi,
  input  logic          hold_n,
  output logic          miso,
  output logic          miso_oe,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic [7:0]    mem_wdata,
  input  logic [7:0]    mem_rdata
);
  localparam int PW = $clog2(PAGE_BYTES);
  localparam int TW = $clog2(WR_TICKS + 1);
  localparam logic [TW-1:0] T_LAST = TW'(WR_TICKS - 1);
  localparam logic [TW-1:0] T_PAGE = TW'(PAGE_BYTES);

  typedef enum logic [3:0] {
    S_IDLE, S_OP, S_ADDR, S_RD, S_WR, S_SRIN, S_SRFULL, S_SROUT, S_WAIT
  } st_t;

  logic [2:0] cs_p, sck_p, hold_p;
  logic [1:0] mosi_p;
  st_t        st;
  logic       is_rd, wel, busy, sr_pend, have_data, oe_r, miso_r, hold_act;
  logic [2:0] bitcnt;
  logic [6:0] sh;
  logic [7:0] txs;
  logic [AW-1:0] addr;
  logic [1:0] bp, sr_new;
  logic [TW-1:0] tcnt;
  logic [7:0] page [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] pvalid;

  wire cs_s      = cs_p[1];
  wire cs_rise   = cs_s & ~cs_p[2];
  wire cs_fall   = ~cs_s & cs_p[2];
  wire sck_s     = sck_p[1];
  wire sck_rise  = sck_s & ~sck_p[2] & ~cs_s & ~hold_act;
  wire sck_fall  = ~sck_s & sck_p[2] & ~cs_s & ~hold_act;
  wire hold_fall = ~hold_p[1] & hold_p[2];
  wire hold_rise = hold_p[1] & ~hold_p[2];
  wire [7:0] rx_byte = {sh, mosi_p[1]};
  wire [7:0] status  = {4'hF, bp, wel, busy};
  wire [7:0] src     = (st == S_RD) ? mem_rdata : status;
  wire wr_go = (st == S_WR) && (bitcnt == 3'd0) && have_data;
  wire sr_go = (st == S_SRFULL);
  wire [PW-1:0] widx = tcnt[PW-1:0];

  assign miso      = miso_r;
  assign miso_oe   = oe_r & ~cs_s & ~hold_act;
  assign mem_addr  = busy ? {addr[AW-1:PW], widx} : addr;
  assign mem_we    = busy && !sr_pend && (tcnt < T_PAGE) && pvalid[widx];
  assign mem_wdata = page[widx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_p <= 3'b111; sck_p <= 3'b000; hold_p <= 3'b111; mosi_p <= 2'b00;
    end else begin
      cs_p   <= {cs_p[1:0], cs_n};
      sck_p  <= {sck_p[1:0], sck};
      hold_p <= {hold_p[1:0], hold_n};
      mosi_p <= {mosi_p[0], mosi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; is_rd <= 1'b0; wel <= 1'b0; busy <= 1'b0; sr_pend <= 1'b0;
      have_data <= 1'b0; oe_r <= 1'b0; miso_r <= 1'b0; hold_act <= 1'b0;
      bitcnt <= '0; sh <= '0; txs <= '0; addr <= '0; bp <= '0; sr_new <= '0;
      tcnt <= '0; pvalid <= '0;
    end else begin
      if (!hold_act && !cs_s && hold_fall && !sck_s) hold_act <= 1'b1;
      else if (hold_act && hold_rise && !sck_s)      hold_act <= 1'b0;

      if (busy) begin
        tcnt <= tcnt + 1'b1;
        if (tcnt == T_LAST) begin
          busy <= 1'b0;
          wel  <= 1'b0;
          if (sr_pend) bp <= sr_new;
        end
      end

      if (cs_rise) begin
        st   <= S_IDLE;
        oe_r <= 1'b0;
        if (wr_go || sr_go) begin
          busy    <= 1'b1;
          sr_pend <= sr_go;
          tcnt    <= '0;
        end
      end else if (cs_fall) begin
        st     <= S_OP;
        bitcnt <= '0;
        oe_r   <= 1'b0;
        if (!busy) begin
          pvalid    <= '0;
          have_data <= 1'b0;
        end
      end else if (sck_rise) begin
        sh     <= rx_byte[6:0];
        bitcnt <= bitcnt + 3'd1;
        if (st == S_SRFULL) st <= S_WAIT;
        if (bitcnt == 3'd7) begin
          case (st)
            S_OP: begin
              if (busy && rx_byte != 8'h05) st <= S_WAIT;
              else begin
                case (rx_byte)
                  8'h06: begin wel <= 1'b1; st <= S_WAIT; end
                  8'h04: begin wel <= 1'b0; st <= S_WAIT; end
                  8'h05: st <= S_SROUT;
                  8'h01: st <= wel ? S_SRIN : S_WAIT;
                  8'h03: begin is_rd <= 1'b1; st <= S_ADDR; end
                  8'h02: begin is_rd <= 1'b0; st <= wel ? S_ADDR : S_WAIT; end
                  default: st <= S_WAIT;
                endcase
              end
            end
            S_ADDR: begin
              addr <= rx_byte[AW-1:0];
              st   <= is_rd ? S_RD : S_WR;
            end
            S_RD: addr <= addr + 1'b1;
            S_WR: begin
              page[addr[PW-1:0]]   <= rx_byte;
              pvalid[addr[PW-1:0]] <= 1'b1;
              have_data            <= 1'b1;
              addr <= {addr[AW-1:PW], addr[PW-1:0] + 1'b1};
            end
            S_SRIN: begin
              sr_new <= rx_byte[3:2];
              st     <= S_SRFULL;
            end
            S_SROUT: begin
              st   <= S_WAIT;
              oe_r <= 1'b0;
            end
            default: ;
          endcase
        end
      end else if (sck_fall && (st == S_RD || st == S_SROUT)) begin
        if (bitcnt == 3'd0) begin
          miso_r <= src[7];
          txs    <= {src[6:0], 1'b0};
          oe_r   <= 1'b1;
        end else begin
          miso_r <= txs[7];
          txs    <= {txs[6:0], 1'b0};
        end
      end
    end
  end
endmodule

module spi_eeprom_fe_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       miso,
  input logic       miso_oe,
  input logic       cs_s,
  input logic       sck_s,
  input logic       hold_act,
  input logic       busy,
  input logic [2:0] bitcnt,
  input logic [1:0] bp
);
  // R11
  oe_needs_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miso_oe |-> !$past(cs_n, 2));
  // R10
  hold_freezes_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_act && !cs_s) |=> (cs_s || $stable(bitcnt)));
  // R6
  commit_on_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(bitcnt) == 3'd0));
  // R7
  protect_update_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bp) |-> $fell(busy));
  // R3
  out_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(miso) |-> !$past(sck_s));
endmodule

bind spi_eeprom_fe spi_eeprom_fe_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .miso(miso), .miso_oe(miso_oe),
  .cs_s(cs_p[1]), .sck_s(sck_p[1]), .hold_act(hold_act), .busy(busy),
  .bitcnt(bitcnt), .bp(bp)
);

// File: tb/test_spi_eeprom_fe.sv
module test_spi_eeprom_fe;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, hold_n = 1'b1;
  logic miso, miso_oe, mem_we;
  logic [7:0] mem_addr, mem_wdata, mem_rdata;
  logic [7:0] mem [256];
  logic [7:0] exp_mem [256];
  int errors = 0, checks = 0;
  logic oe_seen;

  always #4 clk = ~clk;

  spi_eeprom_fe #(.WR_TICKS(1000)) i_spi_eeprom_fe (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi), .hold_n(hold_n),
    .miso(miso), .miso_oe(miso_oe), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hp();
    repeat (8) @(negedge clk);
  endtask

  task automatic spi_bit(input logic b, output logic r);
    mosi = b;
    hp();
    r = miso;
    if (miso_oe) oe_seen = 1'b1;
    sck = 1'b1;
    hp();
    sck = 1'b0;
  endtask

  task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) spi_bit(tx[i], rx[i]);
  endtask

  task automatic sel();
    cs_n = 1'b0; oe_seen = 1'b0; hp();
  endtask

  task automatic desel();
    hp(); cs_n = 1'b1; repeat (4) hp();
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] d;
    sel(); spi_byte(op, d); desel();
  endtask

  task automatic rd_status(output logic [7:0] s);
    logic [7:0] d;
    sel(); spi_byte(8'h05, d); spi_byte(8'hFF, s); desel();
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    for (int i = 0; i < 60; i++) begin
      rd_status(s);
      if (!s[0]) break;
    end
  endtask

  task automatic read_check(input logic [7:0] a, input int n, input string req);
    logic [7:0] d;
    sel(); spi_byte(8'h03, d); spi_byte(a, d);
    for (int i = 0; i < n; i++) begin
      spi_byte(8'h00, d);
      chk(req, d, exp_mem[8'(a + i)]);
    end
    desel();
  endtask

  task automatic t_reset();
    logic [7:0] s;
    chk("R1 oe after reset", miso_oe, 0);
    rd_status(s);
    chk("R1 status after reset", s, 8'hF0);
  endtask

  task automatic t_wel();
    logic [7:0] s;
    cmd1(8'h06); rd_status(s); chk("R2 latch set", s, 8'hF2);
    cmd1(8'h04); rd_status(s); chk("R2 latch clear", s, 8'hF0);
  endtask

  task automatic t_status_wait();
    logic [7:0] d, s;
    sel(); spi_byte(8'h05, d);
    chk("R11 no oe in command phase", oe_seen, 0);
    spi_byte(8'hFF, s);
    chk("R3 status byte", s, 8'hF0);
    chk("R3 oe during status", oe_seen, 1);
    oe_seen = 1'b0;
    spi_byte(8'h06, d);
    chk("R3 oe low after status byte", oe_seen, 0);
    desel();
    rd_status(s);
    chk("R3 input ignored after status", s, 8'hF0);
  endtask

  task automatic t_read();
    logic [7:0] d;
    sel(); spi_byte(8'h03, d); spi_byte(8'hFE, d);
    chk("R11 no oe in address phase", oe_seen, 0);
    for (int i = 0; i < 4; i++) begin
      spi_byte(8'h00, d);
      chk("R4 streamed read with wrap", d, exp_mem[8'(8'hFE + i)]);
    end
    desel();
  endtask

  task automatic t_write();
    logic [7:0] d, s;
    cmd1(8'h06);
    sel(); spi_byte(8'h02, d); spi_byte(8'h1E, d);
    spi_byte(8'hA1, d); spi_byte(8'hB2, d); spi_byte(8'hC3, d); spi_byte(8'hD4, d);
    desel();
    exp_mem[8'h1E] = 8'hA1; exp_mem[8'h1F] = 8'hB2;
    exp_mem[8'h10] = 8'hC3; exp_mem[8'h11] = 8'hD4;
    rd_status(s);
    chk("R5 busy with latch set", s, 8'hF3);
    sel(); spi_byte(8'h03, d); spi_byte(8'h10, d); spi_byte(8'h00, d); desel();
    chk("R9 read rejected while busy", oe_seen, 0);
    wait_idle();
    rd_status(s);
    chk("R5 latch cleared after cycle", s, 8'hF0);
    read_check(8'h10, 16, "R5 page contents with wrap");
  endtask

  task automatic t_discard();
    logic [7:0] d, s;
    sel(); spi_byte(8'h02, d); spi_byte(8'h40, d); spi_byte(8'h77, d); desel();
    rd_status(s);
    chk("R6 no cycle without latch", s, 8'hF0);
    cmd1(8'h06);
    sel(); spi_byte(8'h02, d); spi_byte(8'h41, d); spi_byte(8'h88, d);
    spi_bit(1'b0, d[0]);
    desel();
    rd_status(s);
    chk("R6 no cycle after extra clock", s, 8'hF2);
    cmd1(8'h04);
    read_check(8'h40, 2, "R6 array unchanged");
  endtask

  task automatic t_wrsr();
    logic [7:0] d, s;
    cmd1(8'h06);
    sel(); spi_byte(8'h01, d); spi_byte(8'h0C, d); desel();
    rd_status(s);
    chk("R7 old field during cycle", s, 8'hF3);
    wait_idle();
    rd_status(s);
    chk("R7 field updated", s, 8'hFC);
    cmd1(8'h06);
    sel(); spi_byte(8'h01, d); spi_byte(8'h00, d); spi_bit(1'b0, d[0]); desel();
    rd_status(s);
    chk("R7 update discarded by ninth clock", s, 8'hFE);
    sel(); spi_byte(8'h01, d); spi_byte(8'h00, d); desel();
    wait_idle();
    rd_status(s);
    chk("R7 field restored", s, 8'hF0);
  endtask

  task automatic t_invalid();
    logic [7:0] d, s;
    sel(); spi_byte(8'hAB, d); spi_byte(8'h05, d); spi_byte(8'hFF, d); desel();
    chk("R8 no output after bad command", oe_seen, 0);
    sel(); spi_byte(8'h5C, d); spi_byte(8'h06, d); desel();
    rd_status(s);
    chk("R8 later command ignored", s, 8'hF0);
  endtask

  task automatic t_hold();
    logic [7:0] d, r;
    sel(); spi_byte(8'h03, d); spi_byte(8'h20, d);
    for (int i = 7; i >= 4; i--) spi_bit(1'b0, r[i]);
    hp();
    hold_n = 1'b0; hp(); hp();
    chk("R10 oe low in hold", miso_oe, 0);
    for (int i = 0; i < 3; i++) begin sck = 1'b1; hp(); sck = 1'b0; hp(); end
    chk("R10 oe still low", miso_oe, 0);
    hold_n = 1'b1; hp();
    for (int i = 3; i >= 0; i--) spi_bit(1'b0, r[i]);
    chk("R10 byte across hold", r, exp_mem[8'h20]);
    spi_byte(8'h00, d);
    chk("R10 next byte after hold", d, exp_mem[8'h21]);
    desel();
  endtask

  task automatic t_oe_drop();
    logic [7:0] d;
    sel(); spi_byte(8'h03, d); spi_byte(8'h30, d); spi_byte(8'h00, d);
    for (int i = 0; i < 3; i++) spi_bit(1'b0, d[i]);
    hp();
    chk("R11 oe high in data phase", miso_oe, 1);
    cs_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11 oe drops after deselect", miso_oe, 0);
    repeat (4) hp();
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i) ^ 8'h5A;
      exp_mem[i] = 8'(i) ^ 8'h5A;
    end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_wel();
    t_status_wait();
    t_read();
    t_write();
    t_discard();
    t_wrsr();
    t_invalid();
    t_hold();
    t_oe_drop();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule